// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block connects a simple single-word host request port to an asynchronous DRAM of 4M four-bit words, organised internally as 2048 rows by 2048 columns. A host access presents a 22-bit word address. The controller splits that address into a row part and a column part and sends both over one shared 11-bit address bus, one after the other. Active-low row and column strobes qualify the two parts. Active-low write-enable and output-enable set the direction on a 4-bit bidirectional data bus.

A refresh interval timer raises a pending request at a fixed cycle interval. When the current access has finished, the controller runs one row-strobe-only cycle on the next row of an internal counter, before it accepts any further host request. A row activation senses the whole row and restores it, which is how each row is refreshed. The row strobe is held low for a restore cycle on every activation, because sensing a row destroys its stored charge. Both strobes then return high for precharge. The host holds its request until it sees a one-cycle acknowledge, so it waits through any refresh that gets in ahead of it.

Top module: `dram_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, all four DRAM control strobes are high and ack_o is low.
- R2: The row address, addr_i[21:11], is driven on the address bus for at least one cycle before the row strobe falls, and it is unchanged at the falling edge.
- R3: The column address, addr_i[10:0], replaces the row on the bus only after the row strobe is low. The column strobe falls only after the row strobe has been low for a full cycle.
- R4: On a write, write-enable is low and the controller drives wdata_i on the data bus when the column strobe falls. Output-enable stays high. Write-enable and output-enable are never low together.
- R5: On a read, output-enable is low and write-enable is high while the column strobe is low. rdata_o holds the value the memory drove, and it is valid in the cycle that ack_o is high.
- R6: Each accepted request yields exactly one ack_o pulse that lasts one cycle, with both strobes high in that cycle.
- R7: When the row strobe rises, the column strobe is also high, and both stay high for at least the next cycle (precharge).
- R8: Every row activation keeps the row strobe low for at least two cycles so that the sensed row is restored. The column strobe is low only while the row strobe is low.
- R9: A refresh is a row-strobe-only activation with the column strobe held high. The row number comes from a counter that starts at 0 after reset, rises by one per refresh, and wraps from 2047 to 0.
- R10: A refresh becomes pending every REF_INTERVAL cycles. An access already in progress finishes first, and the refresh runs before the next host request is accepted. As a result, every row is activated within 2048*REF_INTERVAL+16 cycles, and a host request is acknowledged at most 11 cycles after it is presented to an idle controller.
- R11: Data written to any address reads back unchanged, even when refreshes fall between the write and the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 22 | Word address: [21:11] row, [10:0] column |
| wdata_i | input | 4 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Read data, valid with ack_o |
| dram_addr_o | output | 11 | Multiplexed row/column address bus |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_io | inout | 4 | Bidirectional data bus |

## Verification
Two conditions are hard to reach from the ports. One is a refresh falling due while a host access is in flight. The other is a refresh falling due in the idle cycle where a waiting request would otherwise be taken. Neither can be timed directly from outside. The stimulus therefore keeps the host busy with back-to-back write and read rounds over a spread of addresses, and it uses a short refresh interval that does not divide the access length. The phase between the refresh timer and the access sequence then drifts, and it lands on each of these alignments many times. The traffic continues until the row counter has wrapped. A bench-side memory model records every row activation, classifies each one as host or refresh, and checks the refresh row order, the gap between activations of each row, the host latency, and the data read back.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW_SET,
    ST_ROW_ACT,
    ST_COL_SET,
    ST_COL_ACT,
    ST_DATA,
    ST_REF_SET,
    ST_REF_ACT,
    ST_REF_RST,
    ST_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    ASEL_ROW,
    ASEL_COL,
    ASEL_REF
  } addr_sel_e;

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned REF_INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic pend_o
);
  localparam int unsigned CW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;
  logic          pend_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // a tick in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else pend_q <= tick | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dram_row_ctr.sv
module dram_row_ctr #(
  parameter int unsigned ROW_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  // natural wrap from all-ones to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else if (step_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      pend_i,
  input  logic      wr_i,
  output logic      accept_o,
  output logic      ref_start_o,
  output logic      ref_done_o,
  output logic      sample_o,
  output logic      ack_o,
  output logic      ras_n_o,
  output logic      cas_n_o,
  output logic      we_n_o,
  output logic      oe_n_o,
  output logic      dq_oe_o,
  output addr_sel_e sel_o
);
  seq_state_e st_q, st_d;
  logic       ref_q;

  assign ref_start_o = (st_q == ST_IDLE) && pend_i;
  assign accept_o    = (st_q == ST_IDLE) && !pend_i && req_i;
  assign ref_done_o  = (st_q == ST_REF_RST);
  assign sample_o    = (st_q == ST_DATA) && !wr_i;
  assign ack_o       = (st_q == ST_PRE) && !ref_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_i) st_d = ST_REF_SET;
        else if (req_i) st_d = ST_ROW_SET;
      end
      ST_ROW_SET: st_d = ST_ROW_ACT;
      ST_ROW_ACT: st_d = ST_COL_SET;
      ST_COL_SET: st_d = ST_COL_ACT;
      ST_COL_ACT: st_d = ST_DATA;
      ST_DATA:    st_d = ST_PRE;
      ST_REF_SET: st_d = ST_REF_ACT;
      ST_REF_ACT: st_d = ST_REF_RST;
      ST_REF_RST: st_d = ST_PRE;
      ST_PRE:     st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ref_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ref_start_o) ref_q <= 1'b1;
      else if (accept_o) ref_q <= 1'b0;
    end
  end

  // strobe decode
  always_comb begin
    ras_n_o = 1'b1;
    cas_n_o = 1'b1;
    we_n_o  = 1'b1;
    oe_n_o  = 1'b1;
    dq_oe_o = 1'b0;
    sel_o   = ASEL_ROW;
    unique case (st_q)
      ST_ROW_SET: sel_o = ASEL_ROW;
      ST_ROW_ACT: begin
        sel_o   = ASEL_ROW;
        ras_n_o = 1'b0;
      end
      ST_COL_SET: begin
        sel_o   = ASEL_COL;
        ras_n_o = 1'b0;
        we_n_o  = !wr_i;
        dq_oe_o = wr_i;
      end
      ST_COL_ACT, ST_DATA: begin
        sel_o   = ASEL_COL;
        ras_n_o = 1'b0;
        cas_n_o = 1'b0;
        we_n_o  = !wr_i;
        oe_n_o  = wr_i;
        dq_oe_o = wr_i;
      end
      ST_REF_SET: sel_o = ASEL_REF;
      ST_REF_ACT, ST_REF_RST: begin
        sel_o   = ASEL_REF;
        ras_n_o = 1'b0;
      end
      default: sel_o = ASEL_ROW;
    endcase
  end
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W        = 11,
  parameter int unsigned COL_W        = 11,
  parameter int unsigned DQ_W         = 4,
  parameter int unsigned REF_INTERVAL = 780,
  localparam int unsigned HA_W  = ROW_W + COL_W,
  localparam int unsigned BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [HA_W-1:0]  addr_i,
  input  logic [DQ_W-1:0]  wdata_i,
  output logic             ack_o,
  output logic [DQ_W-1:0]  rdata_o,
  output logic [BUS_W-1:0] dram_addr_o,
  output logic             dram_ras_no,
  output logic             dram_cas_no,
  output logic             dram_we_no,
  output logic             dram_oe_no,
  inout  wire  [DQ_W-1:0]  dram_dq_io
);
  logic             pend, accept, ref_start, ref_done, sample, dq_oe;
  addr_sel_e        sel;
  logic [ROW_W-1:0] ref_row;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DQ_W-1:0]  wd_q, rd_q;

  dram_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ref_start),
    .pend_o(pend)
  );

  dram_row_ctr #(.ROW_W(ROW_W)) u_rowctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(ref_done),
    .row_o (ref_row)
  );

  dram_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .pend_i     (pend),
    .wr_i       (wr_q),
    .accept_o   (accept),
    .ref_start_o(ref_start),
    .ref_done_o (ref_done),
    .sample_o   (sample),
    .ack_o      (ack_o),
    .ras_n_o    (dram_ras_no),
    .cas_n_o    (dram_cas_no),
    .we_n_o     (dram_we_no),
    .oe_n_o     (dram_oe_no),
    .dq_oe_o    (dq_oe),
    .sel_o      (sel)
  );

  // capture host request on acceptance; row is the upper address part
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
      wr_q  <= 1'b0;
      wd_q  <= '0;
    end else if (accept) begin
      row_q <= addr_i[HA_W-1:COL_W];
      col_q <= addr_i[COL_W-1:0];
      wr_q  <= we_i;
      wd_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (sample) rd_q <= dram_dq_io;
  end

  assign rdata_o = rd_q;

  always_comb begin
    unique case (sel)
      ASEL_COL: dram_addr_o = BUS_W'(col_q);
      ASEL_REF: dram_addr_o = BUS_W'(ref_row);
      default:  dram_addr_o = BUS_W'(row_q);
    endcase
  end

  for (genvar b = 0; b < DQ_W; b++) begin : g_dq
    assign dram_dq_io[b] = dq_oe ? wd_q[b] : 1'bz;
  end
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int unsigned BUS_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [BUS_W-1:0] addr,
  input logic             ack
);
  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n) |-> $stable(addr));

  p_col_after_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n) |-> (!ras_n && !$past(ras_n)));

  p_dir_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n && !oe_n));

  p_ack_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !ack);

  p_ack_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |-> (ras_n && cas_n));

  p_precharge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n) |-> cas_n ##1 (ras_n && cas_n));

  p_restore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n) |=> !ras_n);

  p_cas_in_row_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n |-> !ras_n);
endmodule

bind dram_ctrl dram_ctrl_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ras_n (dram_ras_no),
  .cas_n (dram_cas_no),
  .we_n  (dram_we_no),
  .oe_n  (dram_oe_no),
  .addr  (dram_addr_o),
  .ack   (ack_o)
);

// File: tb/sim_dram_ctrl.sv
`timescale 1ns/1ps
module sim_dram_ctrl;
  localparam int ROW_W = 11;
  localparam int COL_W = 11;
  localparam int NROWS = 1 << ROW_W;
  localparam int RI    = 24;
  localparam int LIMIT = NROWS * RI + 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [21:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        ack;
  logic [3:0]  rdata;
  logic [10:0] d_addr;
  logic        ras_n, cas_n, we_n, oe_n;
  wire  [3:0]  dq;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(4), .REF_INTERVAL(RI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .dram_addr_o(d_addr),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_oe_no(oe_n), .dram_dq_io(dq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // ---------------- memory model and pin monitor ----------------
  logic [3:0]  mem [int];
  logic [3:0]  sb  [int];
  int          last_act [NROWS];
  logic        cur_we;
  logic [21:0] cur_addr;
  logic [3:0]  cur_wd;
  logic [3:0]  rd_val = '0;
  logic        prev_ras = 1'b1, prev_cas = 1'b1;
  logic [10:0] prev_addr = '0;
  logic [10:0] act_row, act_col;
  bit          cas_seen;
  int          ras_lo_run = 0, ras_hi_run = 0;
  int          ref_cnt = 0;

  assign dq = (!ras_n && !cas_n && !oe_n && we_n) ? rd_val : 4'bzzzz;

  initial foreach (last_act[i]) last_act[i] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cas_n && ras_n) chk(0, "R8 cas low with ras high", 1, 0);
      if (prev_ras && !ras_n) begin
        chk(d_addr == prev_addr, "R2 row stable before ras", d_addr, prev_addr);
        chk(ras_hi_run >= 2, "R7 precharge length", ras_hi_run, 2);
        chk(cyc - last_act[d_addr] <= LIMIT, "R10 row gap", cyc - last_act[d_addr], LIMIT);
        last_act[d_addr] = cyc;
        act_row  = d_addr;
        cas_seen = 0;
      end
      if (prev_cas && !cas_n) begin
        chk(!prev_ras, "R3 cas after ras", prev_ras, 0);
        act_col  = d_addr;
        cas_seen = 1;
        if (!we_n) begin
          chk(oe_n, "R4 oe high on write", oe_n, 1);
          chk(dq == cur_wd, "R4 write data on bus", dq, cur_wd);
          mem[{act_row, act_col}] = dq;
        end else begin
          chk(!oe_n, "R5 oe low on read", oe_n, 0);
          rd_val = mem.exists({act_row, act_col}) ? mem[{act_row, act_col}] : 4'h0;
        end
      end
      if (!prev_ras && ras_n) begin
        chk(ras_lo_run >= 2, "R8 ras low length", ras_lo_run, 2);
        chk(cas_n, "R7 cas high at ras rise", cas_n, 1);
        if (cas_seen) begin
          chk(act_row == cur_addr[21:11], "R2 host row", act_row, cur_addr[21:11]);
          chk(act_col == cur_addr[10:0], "R3 host col", act_col, cur_addr[10:0]);
        end else begin
          chk(act_row == 11'(ref_cnt % NROWS), "R9 refresh row order", act_row, ref_cnt % NROWS);
          ref_cnt++;
        end
      end
      ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      prev_ras  = ras_n;
      prev_cas  = cas_n;
      prev_addr = d_addr;
    end else begin
      ras_hi_run = 2;
    end
  end

  // ---------------- host access ----------------
  task automatic do_access(input logic w, input logic [21:0] a, input logic [3:0] d,
                           output logic [3:0] q);
    int lat;
    @(negedge clk);
    cur_we = w; cur_addr = a; cur_wd = d;
    req = 1'b1; we = w; addr = a; wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 64);
    q = rdata;
    req = 1'b0;
    chk(lat <= 11, "R10 host latency", lat, 11);
    chk(ras_n && cas_n, "R6 strobes idle at ack", {ras_n, cas_n}, 3);
    @(negedge clk);
    chk(!ack, "R6 ack single cycle", ack, 0);
  endtask

  task automatic wr(input logic [21:0] a, input logic [3:0] d);
    logic [3:0] q;
    do_access(1'b1, a, d, q);
    sb[a] = d;
  endtask

  task automatic rd_chk(input logic [21:0] a, input string tag);
    logic [3:0] q;
    do_access(1'b0, a, 4'h0, q);
    chk(q == sb[a], tag, q, sb[a]);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high in reset",
        {ras_n, cas_n, we_n, oe_n}, 4'hf);
    chk(!ack, "R1 ack low in reset", ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high after reset",
        {ras_n, cas_n, we_n, oe_n}, 4'hf);
    chk(!ack, "R1 ack low after reset", ack, 0);
  endtask

  task automatic t_patterns();
    wr(22'h000000, 4'h5);
    wr(22'h3FFFFF, 4'hA);
    wr(22'h2AAAAA, 4'hF);
    wr(22'h155555, 4'h0);
    wr(22'h000800, 4'h3);
    rd_chk(22'h000000, "R5 read low corner");
    rd_chk(22'h3FFFFF, "R5 read high corner");
    rd_chk(22'h2AAAAA, "R5 read pattern a");
    rd_chk(22'h155555, "R5 read pattern b");
    rd_chk(22'h000800, "R5 read row one");
    wr(22'h3FFFFF, 4'h6);
    rd_chk(22'h3FFFFF, "R4 overwrite");
    rd_chk(22'h000000, "R4 neighbour untouched");
  endtask

  task automatic t_stream();
    int r = 0;
    while (cyc < (NROWS + 60) * RI) begin
      for (int k = 0; k < 64; k++)
        wr(22'(k * 22'h0F3A5B + 22'h01234), 4'((k + r * 7) & 15));
      for (int k = 0; k < 64; k++)
        rd_chk(22'(k * 22'h0F3A5B + 22'h01234), "R11 read after write across refresh");
      r++;
    end
  endtask

  task automatic t_final();
    int bad = 0;
    repeat (40) @(negedge clk);
    chk(ref_cnt > NROWS, "R9 refresh counter wrapped", ref_cnt, NROWS + 1);
    chk(ref_cnt >= cyc / RI - 2, "R10 refresh rate", ref_cnt, cyc / RI - 2);
    foreach (last_act[i]) if (cyc - last_act[i] > LIMIT) bad++;
    chk(bad == 0, "R10 all rows refreshed", bad, 0);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_stream();
    t_final();
    finish_sim();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_sim();
  end
endmodule